// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 18-bit words that moves data from a write clock domain to an unrelated read clock domain. Storage depth is a power of two set by a parameter. Write and read pointers cross between the domains as Gray codes through two-stage synchronisers. Each domain works out its own word count from its local pointer and the synchronised remote pointer.

Two read behaviours are available, chosen by a mode pin that is captured while the read side is in reset:

- **Standard mode:** a read request loads the next word into the output register on that read-clock edge.
- **Fall-through mode:** the output register is refilled by itself, so the oldest word is already on the output before any request. A request consumes that word and brings up the next one. In this mode the output register counts as one extra word of capacity.

Four active-low status outputs are provided: full, empty, almost-empty and almost-full. Each flag changes only on an edge of the clock of its own domain. The two threshold offsets are static configuration inputs.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: While both resets are held low and after both are released with no traffic, `empty_n`=0, `almost_empty_n`=0, `full_n`=1, `almost_full_n`=1 and `rd_data`=0, provided `af_level` is smaller than the effective depth.
- R2: Words leave the FIFO in the order they were accepted, in both read modes.
- R3: `full_n` is low when the storage holds 2^ADDR_W words. A write while `full_n` is low is dropped: it does not change any stored word or the write pointer.
- R4: A read while `empty_n` is low is dropped: `rd_data` keeps its value and the read pointer does not move.
- R5: In standard mode (`fallthru_mode`=0 at reset), `rd_data` takes the next word on the read-clock edge where `rd_en`=1 and `empty_n`=1. `empty_n` is high while at least one word is stored.
- R6: In fall-through mode (`fallthru_mode`=1 at reset), the oldest word appears on `rd_data` with `rd_en` held low. While `empty_n`=1 and `rd_en`=0, `rd_data` holds. `rd_en`=1 consumes the word shown.
- R7: In standard mode, `almost_empty_n` is low when the count is at most `ae_level` and high when the count is `ae_level`+1 or more.
- R8: In fall-through mode, `almost_empty_n` is low when the count is at most `ae_level`+1 and high when the count is `ae_level`+2 or more.
- R9: `almost_full_n` is low when the count is at least D-`af_level`, where D=2^ADDR_W in standard mode and 2^ADDR_W+1 in fall-through mode. It is high below that count.
- R10: The read mode is captured only while reset is low. Changing `fallthru_mode` after reset has no effect, so in standard mode a written word does not appear on `rd_data` until it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full_n | output | 1 | Low when storage is full |
| almost_full_n | output | 1 | Low at or above the almost-full threshold |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output register |
| empty_n | output | 1 | Low when no word is readable |
| almost_empty_n | output | 1 | Low at or below the almost-empty threshold |
| fallthru_mode | input | 1 | Read mode, captured during reset (1 = fall-through) |
| ae_level | input | ADDR_W+1 | Almost-empty offset |
| af_level | input | ADDR_W+1 | Almost-full offset |

## Verification
A write or read pointer that has gone wrong shows up at the ports in two ways:
- a word read back out of order or repeated, the first time the affected slot is read;
- a flag that disagrees with the bench's reference count, a few cycles later, once the synchronisers have settled.

A lost or stuck fall-through output register shows as `empty_n` staying low, or as a stale `rd_data`, within one read cycle of the refill. For this reason every flag is compared only after a settling gap of several cycles in both domains, and every data word is compared as it is consumed.

// File: rtl/dcf_pkg.sv
// Shared definitions for the dual-clock FIFO with threshold flags.
// Assumes nothing beyond standard SystemVerilog.
package dcf_pkg;
    typedef enum logic {
        RD_STANDARD = 1'b0,
        RD_FALLTHRU = 1'b1
    } rd_mode_e;

    localparam int unsigned WORD_W = 18;
endpackage

// File: rtl/dcf_ptr_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, followed by conversion back
// to binary in the destination domain.
// Assumes the source changes at most one bit per source-clock edge.
module dcf_ptr_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: move the Gray pointer through two destination-domain flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    // Purpose: turn the synchronised Gray value back into binary.
    always_comb begin
        bin_out[W-1] = stage2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2_q[i];
        end
    end
endmodule

// File: rtl/dcf_mem.sv
// Word storage: one write port clocked by the write clock, and a
// combinational read port that the read controller registers.
// Assumes the caller never writes the slot being read in the same cycle
// (the pointer logic guarantees this).
module dcf_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int SLOTS = 2 ** ADDR_W;

    logic [DATA_W-1:0] store_q [SLOTS];

    // Purpose: store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-side controller. Owns the write pointer and drives the full and
// almost-full flags from write-domain registers only.
// Assumes:
//  - rd_bin_s is the storage read pointer, already synchronised;
//  - usr_bin_s is the consumed-word pointer, already synchronised.
// Full is taken from storage occupancy.
// Almost-full is taken from the user-visible count, which includes the
// fall-through output register.
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PW     = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              mode_in,
    input  logic [ADDR_W:0]   af_offset,
    input  logic [PW-1:0]     rd_bin_s,
    input  logic [PW-1:0]     usr_bin_s,
    output logic [PW-1:0]     wbin,
    output logic [PW-1:0]     wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic              full_n,
    output logic              almost_full_n
);
    localparam logic [PW-1:0] DEPTH_P = PW'(2 ** ADDR_W);
    localparam int XW = PW + 1;

    rd_mode_e      mode_q;
    logic [PW-1:0] ram_cnt;
    logic [PW-1:0] usr_cnt;
    logic [PW-1:0] wbin_nx;
    logic [XW-1:0] eff_depth;
    logic [XW-1:0] af_sum;

    // Purpose: capture the read mode while reset is low, and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rd_mode_e'(mode_in);
        end
    end

    assign ram_cnt = wbin - rd_bin_s;
    assign usr_cnt = wbin - usr_bin_s;
    assign full_n  = (ram_cnt < DEPTH_P);
    assign we      = wr_en && full_n;
    assign wbin_nx = wbin + PW'(we);
    assign waddr   = wbin[ADDR_W-1:0];

    // Purpose: advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    assign eff_depth     = XW'(DEPTH_P) + XW'(mode_q == RD_FALLTHRU);
    assign af_sum        = XW'(usr_cnt) + XW'(af_offset);
    assign almost_full_n = (af_sum < eff_depth);

    // Storage never holds more than its depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cnt <= DEPTH_P);

    // A write attempted while full leaves the write pointer where it was.
    p_full_drops_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_en) |=> (wbin == $past(wbin)));

    // In standard mode, full implies almost-full.
    p_full_implies_af_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && mode_q == RD_STANDARD) |-> !almost_full_n);
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-side controller. Owns two pointers and the output register:
//  - the storage read pointer;
//  - the consumed-word pointer, which trails the storage pointer by one while
//    the fall-through output register is loaded.
// Drives empty and almost-empty from read-domain registers only.
// Assumes wr_bin_s is the synchronised write pointer.
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    parameter int PW     = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              mode_in,
    input  logic [ADDR_W:0]   ae_offset,
    input  logic [PW-1:0]     wr_bin_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PW-1:0]     rgray,
    output logic [PW-1:0]     ugray,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n
);
    localparam int XW = PW + 1;

    rd_mode_e      mode_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] ubin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] ubin_nx;
    logic [PW-1:0] ram_cnt;
    logic [PW-1:0] tot_cnt;
    logic [XW-1:0] ae_limit;
    logic          out_valid;
    logic          fetch;
    logic          user_rd;
    logic          fallthru;

    // Purpose: capture the read mode while reset is low, and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= rd_mode_e'(mode_in);
        end
    end

    assign fallthru = (mode_q == RD_FALLTHRU);
    assign ram_cnt  = wr_bin_s - rbin;
    assign tot_cnt  = wr_bin_s - ubin;
    assign raddr    = rbin[ADDR_W-1:0];

    // Purpose: decide whether storage is read into the output register, and
    // whether the user consumes a word, this cycle.
    always_comb begin
        if (fallthru) begin
            fetch   = (ram_cnt != '0) && (!out_valid || rd_en);
            user_rd = rd_en && out_valid;
        end else begin
            fetch   = rd_en && (ram_cnt != '0);
            user_rd = fetch;
        end
    end

    assign rbin_nx = rbin + PW'(fetch);
    assign ubin_nx = ubin + PW'(user_rd);

    // Purpose: update the pointers, their Gray copies and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin      <= '0;
            ubin      <= '0;
            rgray     <= '0;
            ugray     <= '0;
            rd_data   <= '0;
            out_valid <= 1'b0;
        end else begin
            rbin  <= rbin_nx;
            ubin  <= ubin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            ugray <= ubin_nx ^ (ubin_nx >> 1);
            if (fetch) begin
                rd_data <= mem_rdata;
            end
            if (!fallthru) begin
                out_valid <= 1'b0;
            end else if (fetch) begin
                out_valid <= 1'b1;
            end else if (user_rd) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign empty_n        = fallthru ? out_valid : (ram_cnt != '0);
    assign ae_limit       = XW'(ae_offset) + XW'(fallthru);
    assign almost_empty_n = (XW'(tot_cnt) > ae_limit);

    // A read attempted while empty leaves the consumed-word pointer where it was.
    p_empty_drops_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_en) |=> (ubin == $past(ubin)));

    // Empty always implies almost-empty.
    p_empty_implies_ae_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // The consumed pointer trails the storage pointer by at most the one word
    // held in the output register.
    p_order_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rbin - ubin) <= PW'(fallthru));

    // In fall-through mode the shown word holds until it is consumed.
    p_fallthru_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fallthru && empty_n && !rd_en) |=> $stable(rd_data));
endmodule

// File: rtl/dcf_pflag_fifo.sv
// Top level of the dual-clock FIFO with threshold flags.
// Connects:
//  - the write and read controllers;
//  - the storage;
//  - three Gray pointer synchronisers (write pointer to the read side; storage
//    read pointer and consumed-word pointer to the write side).
// Assumes both resets are held low together for a few cycles of each clock,
// with the mode pin stable during that time.
module dcf_pflag_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W = int'(WORD_W),
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              almost_full_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n,
    input  logic              fallthru_mode,
    input  logic [ADDR_W:0]   ae_level,
    input  logic [ADDR_W:0]   af_level
);
    localparam int PW = ADDR_W + 2;

    logic [PW-1:0]     wbin;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     ugray;
    logic [PW-1:0]     wbin_at_rd;
    logic [PW-1:0]     rbin_at_wr;
    logic [PW-1:0]     ubin_at_wr;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              we;

    dcf_wr_ctl #(.ADDR_W(ADDR_W), .PW(PW)) wr_ctl_i (
        .clk           (wr_clk),
        .rst_n         (wr_rst_n),
        .wr_en         (wr_en),
        .mode_in       (fallthru_mode),
        .af_offset     (af_level),
        .rd_bin_s      (rbin_at_wr),
        .usr_bin_s     (ubin_at_wr),
        .wbin          (wbin),
        .wgray         (wgray),
        .waddr         (waddr),
        .we            (we),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PW(PW)) rd_ctl_i (
        .clk            (rd_clk),
        .rst_n          (rd_rst_n),
        .rd_en          (rd_en),
        .mode_in        (fallthru_mode),
        .ae_offset      (ae_level),
        .wr_bin_s       (wbin_at_rd),
        .mem_rdata      (mem_rdata),
        .raddr          (raddr),
        .rgray          (rgray),
        .ugray          (ugray),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

    dcf_ptr_sync #(.W(PW)) wsync_i (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wgray),
        .bin_out (wbin_at_rd)
    );

    dcf_ptr_sync #(.W(PW)) rsync_i (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (rgray),
        .bin_out (rbin_at_wr)
    );

    dcf_ptr_sync #(.W(PW)) usync_i (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (ugray),
        .bin_out (ubin_at_wr)
    );

    // The synchronised write pointer never runs ahead of the real one.
    p_sync_not_ahead_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
        (wbin - wbin_at_rd) <= PW'(2 ** ADDR_W));
endmodule

// File: tb/dcf_pflag_fifo_tb_top.sv
// Self-checking bench: a table of write/read bursts walked in both read modes,
// then directed tests for reset, dropped reads, mode capture and fall-through.
module dcf_pflag_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = CLK_PERIOD + 4;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 18;
    localparam int DEPTH      = 2 ** ADDR_W;
    localparam int AE_N       = 3;
    localparam int AF_M       = 2;
    localparam int VEC_N      = 11;
    localparam int VEC_WR [VEC_N] = '{3, 1, 1, 8, 1, 1, 1, 2, 0, 0, 0};
    localparam int VEC_RD [VEC_N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 12, 8};

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              full_n;
    logic              almost_full_n;
    logic              empty_n;
    logic              almost_empty_n;
    logic              fallthru_mode = 1'b0;
    logic [ADDR_W:0]   ae_level = (ADDR_W+1)'(AE_N);
    logic [ADDR_W:0]   af_level = (ADDR_W+1)'(AF_M);

    int                n_chk = 0;
    int                n_err = 0;
    int                head = 0;
    int                tail = 0;
    bit                fw = 1'b0;
    logic [DATA_W-1:0] seq = 18'h00101;
    logic [DATA_W-1:0] model_q [256];

    dcf_pflag_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .wr_clk         (wr_clk),
        .wr_rst_n       (wr_rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .full_n         (full_n),
        .almost_full_n  (almost_full_n),
        .rd_clk         (rd_clk),
        .rd_rst_n       (rd_rst_n),
        .rd_en          (rd_en),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n),
        .fallthru_mode  (fallthru_mode),
        .ae_level       (ae_level),
        .af_level       (af_level)
    );

    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    always #(RD_PERIOD / 2) rd_clk = ~rd_clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    task automatic do_reset(input bit fall);
        fw            = fall;
        fallthru_mode = fall;
        wr_rst_n      = 1'b0;
        rd_rst_n      = 1'b0;
        wr_en         = 1'b0;
        rd_en         = 1'b0;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        head = 0;
        tail = 0;
        settle();
    endtask

    // Called at a write-clock falling edge; leaves at the next one.
    task automatic write_one();
        wr_data = seq;
        wr_en   = 1'b1;
        if (full_n) begin
            model_q[tail % 256] = seq;
            tail++;
        end
        seq = seq + 18'h00b3d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Called at a read-clock falling edge; leaves at the next one.
    task automatic read_one();
        bit ok;
        ok = empty_n;
        if (fw && ok) begin
            chk("R6/R2 fall-through data", int'(rd_data), int'(model_q[head % 256]));
            head++;
        end
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (!fw && ok) begin
            chk("R5/R2 standard data", int'(rd_data), int'(model_q[head % 256]));
            head++;
        end
    endtask

    task automatic check_flags();
        int cnt;
        int d;
        cnt = tail - head;
        d   = DEPTH + int'(fw);
        chk(fw ? "R6 empty_n" : "R5 empty_n", int'(empty_n), int'(cnt > 0));
        chk(fw ? "R8 almost_empty_n" : "R7 almost_empty_n", int'(almost_empty_n),
            int'(!(cnt <= AE_N + int'(fw))));
        chk("R9 almost_full_n", int'(almost_full_n), int'(!(cnt >= d - AF_M)));
        chk("R3 full_n", int'(full_n), int'(!(cnt >= d)));
    endtask

    task automatic walk_table();
        for (int v = 0; v < VEC_N; v++) begin
            @(negedge wr_clk);
            for (int k = 0; k < VEC_WR[v]; k++) write_one();
            @(negedge rd_clk);
            for (int k = 0; k < VEC_RD[v]; k++) read_one();
            settle();
            check_flags();
        end
    endtask

    task automatic check_reset_state();
        chk("R1 empty_n after reset", int'(empty_n), 0);
        chk("R1 almost_empty_n after reset", int'(almost_empty_n), 0);
        chk("R1 full_n after reset", int'(full_n), 1);
        chk("R1 almost_full_n after reset", int'(almost_full_n), 1);
        chk("R1 rd_data after reset", int'(rd_data), 0);
    endtask

    initial begin
        logic [DATA_W-1:0] held;

        // R1: standard-mode reset state.
        do_reset(1'b0);
        check_reset_state();

        // R10: the mode pin changed after reset must not enable fall-through.
        fallthru_mode = 1'b1;
        @(negedge wr_clk);
        write_one();
        settle();
        chk("R10 no fall-through after mode change", int'(rd_data), 0);
        chk("R10 empty_n with one word", int'(empty_n), 1);
        read_one();
        settle();
        check_flags();

        // Table walk in standard mode: R3, R5, R7, R9, R2.
        do_reset(1'b0);
        walk_table();

        // R4: a read while empty keeps rd_data and leaves the FIFO empty.
        held = rd_data;
        read_one();
        settle();
        chk("R4 rd_data held on empty read", int'(rd_data), int'(held));
        chk("R4 still empty", int'(empty_n), 0);
        @(negedge wr_clk);
        write_one();
        settle();
        read_one();
        settle();
        check_flags();

        // Fall-through mode: R1 reset state, then R6 head word without a request.
        do_reset(1'b1);
        check_reset_state();
        @(negedge wr_clk);
        write_one();
        settle();
        chk("R6 head word shown without request", int'(rd_data), int'(model_q[head % 256]));
        chk("R6 empty_n with one word", int'(empty_n), 1);
        read_one();
        settle();
        check_flags();

        // Table walk in fall-through mode: R8, R9 with D = DEPTH+1, R3, R2.
        walk_table();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule